// File: doc/BRIEF.md
# Programmable Skew Clock Output Bank

This block drives four clock output pairs from one reference clock. The block is fully digital and runs on a fast tick clock. One tick is the block's time unit. The reference is brought across on that clock and fed into a tapped delay line whose middle tap is the zero-skew point. Each output pair reads the tap its control code selects, so the pair can lead or lag the reference by a whole number of ticks.

Two of the pairs move in steps of one tick. The other two move in steps of two ticks, and on those two pairs the end codes give divided or inverted outputs. Every three-level control arrives already decoded as a 2-bit level. A synchronous stop input parks the outputs at their resting level. The feedback pair keeps running while the stop input is high. An edge-select input picks which reference edge the outputs follow, rising or falling. A test input turns the stop input into a per-pair disable.

Top module: `skew_clk_bank`

## Requirements
- R1: Each pair has a 4-bit code in `ctrl_i[4p+3:4p]`, with the upper level in bits 3:2 and the lower level in bits 1:0. Levels are encoded as 00 = L, 01 = M, 10 = H, and 11 is read as M (undriven). The code index is 3*upper + lower, giving 0 for LL through 8 for HH.
- R2: Pairs 0 and 1 are skewed by (index − 4) ticks. After the first `clk_i` rising edge that samples a synchronizing reference edge, the matching output rising edge appears on the `clk_i` edge 9 + skew cycles later.
- R3: Pairs 2 and 3 are skewed by 2*(index − 4) ticks for indices 1 to 7, with the same timing rule as R2.
- R4: On pairs 2 and 3, index 0 gives a divide-by-2 output. Its rising edges come at the zero-skew time of every second synchronizing edge.
- R5: On pair 2, index 8 gives a divide-by-4 output. Each of its rising edges coincides with a rising edge of the divide-by-2 output.
- R6: On pair 3, index 8 gives the zero-skew output inverted. Its falling edge sits at the zero-skew time.
- R7: With `edge_sel_i` = 1 the outputs follow rising reference edges. With `edge_sel_i` = 0 they follow falling reference edges, and this includes the divided outputs.
- R8: With `stop_i` = 1 and `test_i` = 0, pairs 0, 1 and 3 are held LOW and pair 2 keeps running.
- R9: While pair 3 is in inverted mode and stopped, it is held at the level of `edge_sel_i`.
- R10: With `test_i` = 1 and `stop_i` = 1, only the pairs at index 0 are held LOW, pair 2 included. The other pairs keep their skew function. With `stop_i` = 0, index 0 works normally.
- R11: Stopping and restarting switch an output only while its ungated waveform is at the resting level. Every HIGH pulse therefore keeps its full width.
- R12: In reset all outputs are LOW. The divider state clears on reset and whenever `edge_sel_i` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock; one period is the skew unit |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ref_i | input | 1 | Reference clock, sampled on clk_i |
| edge_sel_i | input | 1 | 1 = follow rising reference edges, 0 = falling |
| stop_i | input | 1 | Synchronous output stop |
| test_i | input | 1 | Turns stop into a per-pair disable for index-0 pairs |
| ctrl_i | input | 16 | Four 4-bit pair codes, pair p at bits 4p+3:4p |
| q_o | output | 8 | Pair p drives bits 2p+1:2p with identical waveforms |

## Verification
The bench measures the offset of the output edge for all nine codes on the fine pairs and all seven skew codes on the coarse pairs. An off-by-one in the tap arithmetic, or a sign error, moves that offset by a tick or mirrors it. The dividers are checked for their period, for alignment with the synchronizing edge, and for rising edges that coincide. A divider that counted the wrong edge, or that started out of phase, would break one of these. The stop input is toggled at awkward points while HIGH pulse widths are measured, so gating that truncated a pulse would show up as a short pulse. The per-pair test disable and the stopped level of the inverted pair are checked under both edge polarities.

// File: rtl/clkbank_pkg.sv
package clkbank_pkg;
  typedef enum logic [1:0] {MODE_SKEW, MODE_DIV2, MODE_DIV4, MODE_INV} pair_mode_e;

  function automatic logic [1:0] lvl_num(input logic [1:0] l);
    case (l)
      2'b00:   return 2'd0;
      2'b10:   return 2'd2;
      default: return 2'd1;  // 01 and undriven 11 read as mid
    endcase
  endfunction

  function automatic logic [3:0] code_index(input logic [3:0] c);
    return 4'(3 * int'(lvl_num(c[3:2]))) + 4'(lvl_num(c[1:0]));
  endfunction
endpackage

// File: rtl/clkbank_ref_front.sv
module clkbank_ref_front #(
  parameter int SYNC_STAGES = 2,
  parameter int NUM_TAPS    = 13
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ref_i,
  input  logic                edge_sel_i,
  output logic [NUM_TAPS-1:0] taps_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic [NUM_TAPS-1:0]    tap_q;
  logic                   aligned;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= ref_i;
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], ref_i};
    end
  endgenerate

  // Falling-edge sync is a polarity flip ahead of the delay line
  assign aligned = edge_sel_i ? sync_q[SYNC_STAGES-1] : ~sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) tap_q <= '0;
    else         tap_q <= {tap_q[NUM_TAPS-2:0], aligned};

  assign taps_o = tap_q;
endmodule

// File: rtl/clkbank_div_gen.sv
module clkbank_div_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic edge_sel_i,
  input  logic rise_i,
  output logic div2_o,
  output logic div4_o
);
  logic [1:0] cnt_q;
  logic       es_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q <= '0;
      es_q  <= 1'b1;
    end else begin
      es_q <= edge_sel_i;
      if (edge_sel_i != es_q) cnt_q <= '0;
      else if (rise_i)        cnt_q <= cnt_q + 2'd1;
    end

  // div4 high for counts 1,2 so both dividers rise on the same edge
  assign div2_o = cnt_q[0];
  assign div4_o = cnt_q[0] ^ cnt_q[1];

  assert_div4_on_div2_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(div4_o) |-> $rose(div2_o));

  assert_div_clear_on_edge_change_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel_i != $past(edge_sel_i)) |=> (!div2_o && !div4_o));
endmodule

// File: rtl/clkbank_pair_out.sv
module clkbank_pair_out import clkbank_pkg::*; #(
  parameter int         CENTER    = 6,
  parameter int         NUM_TAPS  = 13,
  parameter int         STEP      = 1,
  parameter bit         END_CODES = 1'b0,
  parameter pair_mode_e HI_MODE   = MODE_DIV4,
  parameter bit         KEEP_RUN  = 1'b0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_TAPS-1:0] taps_i,
  input  logic                div2_i,
  input  logic                div4_i,
  input  logic [3:0]          code_i,
  input  logic                stop_i,
  input  logic                test_i,
  input  logic                edge_sel_i,
  output logic                q_o
);
  localparam int IW = $clog2(NUM_TAPS);

  logic [3:0]  idx_c;
  pair_mode_e  mode_c;
  logic [IW-1:0] tap_sel;
  logic        raw_c, off_lvl, req_c, en_eff, q_d;
  logic        en_q, q_q;

  always_comb begin
    int t;
    idx_c = code_index(code_i);
    t     = CENTER + STEP * (int'(idx_c) - 4);
    tap_sel = IW'(t);
    if (END_CODES && idx_c == 4'd0)      mode_c = MODE_DIV2;
    else if (END_CODES && idx_c == 4'd8) mode_c = HI_MODE;
    else                                 mode_c = MODE_SKEW;
  end

  always_comb begin
    case (mode_c)
      MODE_DIV2: raw_c = div2_i;
      MODE_DIV4: raw_c = div4_i;
      MODE_INV:  raw_c = ~taps_i[CENTER];
      default:   raw_c = taps_i[tap_sel];
    endcase
  end

  assign off_lvl = (mode_c == MODE_INV) ? edge_sel_i : 1'b0;
  assign req_c   = test_i ? (stop_i && idx_c == 4'd0) : (stop_i && !KEEP_RUN);
  // Enable only moves while the ungated wave rests at the off level
  assign en_eff  = (raw_c == off_lvl) ? !req_c : en_q;
  assign q_d     = en_eff ? raw_c : off_lvl;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      en_q <= 1'b0;
      q_q  <= 1'b0;
    end else begin
      en_q <= en_eff;
      q_q  <= q_d;
    end

  assign q_o = q_q;

  assert_no_runt_rise_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(q_q) && $past(mode_c) != MODE_INV) |-> $past(raw_c));

  assert_no_runt_fall_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(q_q) && $past(mode_c) != MODE_INV && $past(en_q)) |-> !$past(raw_c));

  assert_stopped_at_rest_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_c && raw_c == off_lvl) |=> (q_q == $past(off_lvl)));
endmodule

// File: rtl/skew_clk_bank.sv
module skew_clk_bank import clkbank_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int CENTER_TAP  = 6,
  parameter int FINE_STEP   = 1,
  parameter int COARSE_STEP = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        ref_i,
  input  logic        edge_sel_i,
  input  logic        stop_i,
  input  logic        test_i,
  input  logic [15:0] ctrl_i,
  output logic [7:0]  q_o
);
  localparam int NUM_PAIRS = 4;
  localparam int NUM_TAPS  = 2 * CENTER_TAP + 1;
  localparam int FB_PAIR   = 2;
  localparam int INV_PAIR  = 3;

  logic [NUM_TAPS-1:0]  taps;
  logic                 div2, div4;
  logic [NUM_PAIRS-1:0] pair_q;

  clkbank_ref_front #(.SYNC_STAGES(SYNC_STAGES), .NUM_TAPS(NUM_TAPS)) u_front (
    .clk_i, .rst_ni, .ref_i, .edge_sel_i, .taps_o(taps)
  );

  clkbank_div_gen u_div (
    .clk_i, .rst_ni, .edge_sel_i,
    .rise_i(taps[CENTER_TAP-1] & ~taps[CENTER_TAP]),
    .div2_o(div2), .div4_o(div4)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam bit COARSE = (p >= FB_PAIR);
    clkbank_pair_out #(
      .CENTER(CENTER_TAP), .NUM_TAPS(NUM_TAPS),
      .STEP(COARSE ? COARSE_STEP : FINE_STEP),
      .END_CODES(COARSE),
      .HI_MODE(p == INV_PAIR ? MODE_INV : MODE_DIV4),
      .KEEP_RUN(p == FB_PAIR)
    ) u_pair (
      .clk_i, .rst_ni, .taps_i(taps), .div2_i(div2), .div4_i(div4),
      .code_i(ctrl_i[4*p +: 4]), .stop_i, .test_i, .edge_sel_i,
      .q_o(pair_q[p])
    );
    assign q_o[2*p +: 2] = {2{pair_q[p]}};
  end
endmodule

// File: tb/sim_skew_clk_bank.sv
module sim_skew_clk_bank;
  localparam int CLK_PER = 10;
  localparam int PER     = 20;
  localparam int LAT     = 10;

  logic clk = 1'b0, rst_n = 1'b0, ref_s = 1'b0, edge_sel = 1'b1, stop = 1'b0, test = 1'b0;
  logic [15:0] ctrl;
  logic [7:0]  q;
  int cyc = 0, n_chk = 0, n_fail = 0;

  always #(CLK_PER/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  skew_clk_bank u0 (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_s), .edge_sel_i(edge_sel),
    .stop_i(stop), .test_i(test), .ctrl_i(ctrl), .q_o(q)
  );

  function automatic logic [1:0] lv(int x);
    return (x == 0) ? 2'b00 : (x == 1) ? 2'b01 : 2'b10;
  endfunction
  function automatic logic [3:0] cv(int idx);
    return {lv(idx / 3), lv(idx % 3)};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: reference generator, pushes expected output edge cycles
  int ph = PER - 1, last_act = -100, exp_d = 0;
  bit push_en = 1'b0;
  int exp_q[$];
  always @(negedge clk) begin
    ph = (ph + 1) % PER;
    if (ph == 0) begin
      ref_s = edge_sel;
      last_act = cyc;
      if (push_en) exp_q.push_back(cyc + LAT + exp_d);
    end else if (ph == PER/2) ref_s = ~edge_sel;
  end

  // monitor: pops and compares at each active output edge
  bit mon_en = 1'b0;
  int mon_pair = 0;
  logic mon_lvl = 1'b1, mon_prev = 1'b0;
  string mon_tag = "";
  always @(negedge clk) begin
    logic cur;
    int e;
    cur = q[2*mon_pair];
    if (mon_en && cur != mon_prev && cur == mon_lvl) begin
      if (exp_q.size() == 0) chk(1'b0, mon_tag, cyc, -1);
      else begin
        e = exp_q.pop_front();
        chk(cyc == e && q[2*mon_pair+1] == cur, mon_tag, cyc, e);
      end
    end
    mon_prev = cur;
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic skew_case(int p, logic [3:0] code, int d, logic lvl, string tag);
    ctrl[4*p +: 4] = code;
    mon_pair = p; mon_lvl = lvl; mon_tag = tag; exp_d = d;
    step(4*PER);
    while (ph != PER - 1) step(1);
    push_en = 1'b1; mon_en = 1'b1;
    step(3*PER);
    push_en = 1'b0; mon_en = 1'b0;
    chk(exp_q.size() == 0, tag, exp_q.size(), 0);
    exp_q.delete();
  endtask

  task automatic div_case(string tag);
    logic p2, p4, c2, c4;
    int l2, l4;
    ctrl[8 +: 4] = cv(8); ctrl[12 +: 4] = cv(0);
    step(6*PER);
    l2 = -1; l4 = -1; p2 = q[6]; p4 = q[4];
    repeat (10*PER) begin
      step(1);
      c2 = q[6]; c4 = q[4];
      if (c2 && !p2) begin
        chk(cyc - last_act == LAT, {tag, " R4 div2 align"}, cyc - last_act, LAT);
        if (l2 >= 0) chk(cyc - l2 == 2*PER, {tag, " R4 div2 period"}, cyc - l2, 2*PER);
        l2 = cyc;
      end
      if (c4 && !p4) begin
        chk(c2 && !p2, {tag, " R5 div4 with div2"}, c2, 1);
        if (l4 >= 0) chk(cyc - l4 == 4*PER, {tag, " R5 div4 period"}, cyc - l4, 4*PER);
        l4 = cyc;
      end
      p2 = c2; p4 = c4;
    end
    ctrl[8 +: 4] = cv(4); ctrl[12 +: 4] = cv(4);
  endtask

  task automatic hold_check(int p, logic lvl, string tag);
    int bad = 0;
    repeat (2*PER) begin
      step(1);
      if (q[2*p] !== lvl || q[2*p+1] !== lvl) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic run_check(int p, string tag);
    int r = 0;
    logic pv;
    pv = q[2*p];
    repeat (2*PER) begin
      step(1);
      if (q[2*p] && !pv) r++;
      pv = q[2*p];
    end
    chk(r == 2, tag, r, 2);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(CLK_PER * 150000);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    ctrl = {4{cv(4)}};
    step(5);
    chk(q == 8'h00, "R12 reset low", q, 0);
    rst_n = 1'b1;
    step(2*PER);

    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 9; i++) skew_case(p, cv(i), i - 4, 1'b1, "R2 fine skew");
      ctrl[4*p +: 4] = cv(4);
    end
    for (int p = 2; p < 4; p++) begin
      for (int i = 1; i < 8; i++) skew_case(p, cv(i), 2*(i - 4), 1'b1, "R3 coarse skew");
      ctrl[4*p +: 4] = cv(4);
    end
    skew_case(3, cv(8), 0, 1'b0, "R6 inverted");
    ctrl[12 +: 4] = cv(4);

    skew_case(0, 4'b1111, 0, 1'b1, "R1 undriven mid");
    skew_case(0, 4'b1110, 1, 1'b1, "R1 undriven upper");
    ctrl[3:0] = cv(4);

    div_case("rising");

    edge_sel = 1'b0;
    step(2*PER);
    skew_case(0, cv(4), 0, 1'b1, "R7 falling zero");
    skew_case(0, cv(0), -4, 1'b1, "R7 falling lead");
    skew_case(2, cv(7), 6, 1'b1, "R7 falling lag");
    skew_case(3, cv(8), 0, 1'b0, "R7 falling inverted");
    ctrl = {4{cv(4)}};
    div_case("R7 falling");
    edge_sel = 1'b1;
    step(2*PER);

    stop = 1'b1;
    step(2*PER);
    hold_check(0, 1'b0, "R8 pair0 held");
    hold_check(1, 1'b0, "R8 pair1 held");
    hold_check(3, 1'b0, "R8 pair3 held");
    run_check(2, "R8 feedback runs");

    ctrl[12 +: 4] = cv(8);
    step(2*PER);
    hold_check(3, 1'b1, "R9 inverted held high");
    edge_sel = 1'b0;
    step(2*PER);
    hold_check(3, 1'b0, "R9 inverted held low");
    edge_sel = 1'b1;
    stop = 1'b0;
    ctrl = {4{cv(4)}};
    step(2*PER);

    test = 1'b1; stop = 1'b1;
    ctrl[3:0] = cv(0); ctrl[11:8] = cv(0); ctrl[15:12] = cv(5);
    step(2*PER);
    hold_check(0, 1'b0, "R10 pair0 LL off");
    hold_check(2, 1'b0, "R10 pair2 LL off");
    run_check(1, "R10 pair1 runs");
    run_check(3, "R10 pair3 runs");
    stop = 1'b0;
    step(2*PER);
    run_check(0, "R10 LL runs when not stopped");
    test = 1'b0;
    ctrl = {4{cv(4)}};
    step(2*PER);

    begin : r11_blk
      int rise_at = -1, pulses = 0;
      logic pv;
      pv = q[0];
      for (int i = 0; i < 14*PER; i++) begin
        if (i % 7 == 3) stop = ~stop;
        step(1);
        if (q[0] && !pv) rise_at = cyc;
        if (!q[0] && pv && rise_at >= 0) begin
          pulses++;
          chk(cyc - rise_at == PER/2, "R11 pulse width", cyc - rise_at, PER/2);
        end
        pv = q[0];
      end
      stop = 1'b0;
      chk(pulses > 0, "R11 pulses seen", pulses, 1);
    end

    step(PER/3);
    rst_n = 1'b0;
    step(3);
    chk(q == 8'h00, "R12 reset mid-run", q, 0);
    rst_n = 1'b1;
    step(2);
    finish_run();
  end
endmodule